// File: doc/BRIEF.md
# BCD Digit Pack/Unpack Converter

This block moves decimal digits between two layouts. In the packing direction it takes a 16-bit word that holds one digit in each byte, such as a pair of ASCII characters, adds a 16-bit adjustment to it, and squeezes the two digit nibbles of the sum into one packed byte. In the unpacking direction it takes one packed byte, spreads its two nibbles into the low nibbles of two bytes, and adds the adjustment to the resulting word. A single operation can therefore both convert and offset, for example turning packed digits straight into printable characters.

Operations arrive on a valid/ready request channel and leave on a valid/ready result channel. In register form the operand comes in on the request and the result is ready one cycle after acceptance. In memory form the block runs a short sequence of single-byte reads and writes on a simple memory port, decrementing the source and destination addresses before every access, and reports the result word together with the final addresses. The block accepts no new request while a memory sequence runs or while a result waits on a stalled consumer. A result is held, unchanged, for as long as `out_ready` is low; a request is taken only in a cycle where both `in_valid` and `in_ready` are high.

Top module: `bcd_digit_converter`

## Requirements
- R1: Pack forms the sum of the source word and the displacement, then builds the byte from sum bits 11..8 (upper nibble) and sum bits 3..0 (lower nibble); 0x3736 with adjustment 0x0000 gives 0x76, with 0x0102 gives 0x88.
- R2: Unpack uses only source bits 7..0, builds the word {4'h0, byte[7:4], 4'h0, byte[3:0]} and adds the displacement; 0x76 with 0x3030 gives 0x3736, whatever source bits 15..8 hold.
- R3: The displacement addition wraps modulo 65536 in both directions; any carry out of bit 15 is lost.
- R4: In register form (`in_mem` = 0) `out_valid` rises at the clock edge after the one that accepts the request, and the reported addresses equal the request's addresses.
- R5: A register-form pack returns `{in_keep_hi, packed byte}` on `out_data`, leaving the upper byte of the destination as supplied.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays unchanged and `in_ready` is low.
- R7: `in_ready` is low from the acceptance of a memory-form request until its result has been presented, and no result is presented while the memory port is busy.
- R8: A memory-form pack reads the byte at source address minus 1 (the low digit byte), then at minus 2 (the high digit byte), writes the packed byte at destination minus 1, and returns `{8'h00, packed byte}` with final addresses source minus 2 and destination minus 1.
- R9: A memory-form unpack reads the byte at source minus 1, writes the low result byte at destination minus 1 and then the high result byte at destination minus 2, and returns the 16-bit word with final addresses source minus 1 and destination minus 2.
- R10: `mem_req` is low out of reset and between operations; once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack` is seen high at a clock edge, which completes the access (read data is taken in that same cycle).
- R11: After reset `out_valid` and `mem_req` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with `in_valid` |
| in_unpack | input | 1 | 1 = unpack, 0 = pack |
| in_mem | input | 1 | 1 = memory form, 0 = register form |
| in_src | input | 16 | Register-form source operand |
| in_disp | input | 16 | Adjustment added to the unpacked word |
| in_keep_hi | input | 8 | Upper destination byte kept by a register-form pack |
| in_src_addr | input | ADDR_W | Memory-form source address before decrement |
| in_dst_addr | input | ADDR_W | Memory-form destination address before decrement |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result when high |
| out_data | output | 16 | Result word |
| out_src_addr | output | ADDR_W | Source address after the operation |
| out_dst_addr | output | ADDR_W | Destination address after the operation |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access completes at this edge |
| mem_rdata | input | 8 | Read data, valid while `mem_ack` is high |

## Verification
The properties assume the consumer and the memory follow the handshakes: `mem_rdata` is meaningful only in the acknowledging cycle, `mem_ack` is raised only while a request is pending, and `in_*` fields matter only in the accepting cycle. The bench drives every input half a period away from the rising edge, its memory model acknowledges only a pending request and only every second cycle so that the hold rule is exercised, and it keeps all memory addresses inside its small model.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int DIGITS = BYTE_W / NIB_W;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_LO,
    SQ_RD_HI,
    SQ_WR_A,
    SQ_WR_B,
    SQ_FIN
  } seq_state_t;
endpackage

// File: rtl/bxu_pack_core.sv
module bxu_pack_core
  import bxu_pkg::*;
(
  input  logic [WORD_W-1:0] src_word,
  input  logic [WORD_W-1:0] disp,
  output logic [BYTE_W-1:0] packed_byte
);
  logic [WORD_W-1:0] adj;
  logic [BYTE_W-1:0] adj_unused_bits;

  assign adj = src_word + disp;

  // digit g of the packed byte comes from byte g of the adjusted word
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign packed_byte[g*NIB_W +: NIB_W] = adj[g*BYTE_W +: NIB_W];
    assign adj_unused_bits[g*NIB_W +: NIB_W] = adj[g*BYTE_W + NIB_W +: NIB_W];
  end
endmodule

// File: rtl/bxu_unpack_core.sv
module bxu_unpack_core
  import bxu_pkg::*;
(
  input  logic [BYTE_W-1:0] src_byte,
  input  logic [WORD_W-1:0] disp,
  output logic [WORD_W-1:0] unpacked_word
);
  logic [WORD_W-1:0] spread;

  for (genvar g = 0; g < DIGITS; g++) begin : g_spread
    assign spread[g*BYTE_W +: BYTE_W] = {{(BYTE_W-NIB_W){1'b0}}, src_byte[g*NIB_W +: NIB_W]};
  end

  assign unpacked_word = spread + disp;
endmodule

// File: rtl/bxu_mem_seq.sv
module bxu_mem_seq
  import bxu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_unpack,
  input  logic [WORD_W-1:0] start_disp,
  input  logic [ADDR_W-1:0] start_src_addr,
  input  logic [ADDR_W-1:0] start_dst_addr,
  output logic              busy,
  output logic              done,
  output logic              op_unpack,
  output logic [WORD_W-1:0] fetched_word,
  output logic [WORD_W-1:0] held_disp,
  input  logic [BYTE_W-1:0] pk_byte,
  input  logic [WORD_W-1:0] up_word,
  output logic [ADDR_W-1:0] src_addr_q,
  output logic [ADDR_W-1:0] dst_addr_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  seq_state_t state;
  logic       step;

  assign step = mem_req && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SQ_IDLE;
      op_unpack    <= 1'b0;
      fetched_word <= '0;
      held_disp    <= '0;
      src_addr_q   <= '0;
      dst_addr_q   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state      <= SQ_RD_LO;
          op_unpack  <= start_unpack;
          held_disp  <= start_disp;
          src_addr_q <= start_src_addr;
          dst_addr_q <= start_dst_addr;
        end
        SQ_RD_LO: if (step) begin
          fetched_word[BYTE_W-1:0] <= mem_rdata;
          src_addr_q <= src_addr_q - ONE;
          state      <= op_unpack ? SQ_WR_A : SQ_RD_HI;
        end
        SQ_RD_HI: if (step) begin
          fetched_word[WORD_W-1:BYTE_W] <= mem_rdata;
          src_addr_q <= src_addr_q - ONE;
          state      <= SQ_WR_A;
        end
        SQ_WR_A: if (step) begin
          dst_addr_q <= dst_addr_q - ONE;
          state      <= op_unpack ? SQ_WR_B : SQ_FIN;
        end
        SQ_WR_B: if (step) begin
          dst_addr_q <= dst_addr_q - ONE;
          state      <= SQ_FIN;
        end
        SQ_FIN: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = src_addr_q - ONE;
    mem_wdata = '0;
    unique case (state)
      SQ_RD_LO, SQ_RD_HI: mem_req = 1'b1;
      SQ_WR_A: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_addr_q - ONE;
        mem_wdata = op_unpack ? up_word[BYTE_W-1:0] : pk_byte;
      end
      SQ_WR_B: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_addr_q - ONE;
        mem_wdata = up_word[WORD_W-1:BYTE_W];
      end
      default: ;
    endcase
  end

  assign busy = (state != SQ_IDLE);
  assign done = (state == SQ_FIN);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

  AST_WRITE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we && op_unpack && !done) |=>
      (done || (mem_we && mem_addr == $past(mem_addr) - ONE))); // R9
endmodule

// File: rtl/bcd_digit_converter.sv
module bcd_digit_converter
  import bxu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_unpack,
  input  logic              in_mem,
  input  logic [15:0]       in_src,
  input  logic [15:0]       in_disp,
  input  logic [7:0]        in_keep_hi,
  input  logic [ADDR_W-1:0] in_src_addr,
  input  logic [ADDR_W-1:0] in_dst_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_data,
  output logic [ADDR_W-1:0] out_src_addr,
  output logic [ADDR_W-1:0] out_dst_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);
  logic              accept, seq_busy, seq_done, seq_unpack;
  logic [WORD_W-1:0] seq_word, seq_disp, core_src, core_disp, up_word;
  logic [BYTE_W-1:0] pk_byte;
  logic [ADDR_W-1:0] seq_src_addr, seq_dst_addr;

  assign in_ready = !seq_busy && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  assign core_src  = seq_busy ? seq_word : in_src;
  assign core_disp = seq_busy ? seq_disp : in_disp;

  bxu_pack_core u_pack (
    .src_word    (core_src),
    .disp        (core_disp),
    .packed_byte (pk_byte)
  );

  bxu_unpack_core u_unpack (
    .src_byte      (core_src[BYTE_W-1:0]),
    .disp          (core_disp),
    .unpacked_word (up_word)
  );

  bxu_mem_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (accept && in_mem),
    .start_unpack   (in_unpack),
    .start_disp     (in_disp),
    .start_src_addr (in_src_addr),
    .start_dst_addr (in_dst_addr),
    .busy           (seq_busy),
    .done           (seq_done),
    .op_unpack      (seq_unpack),
    .fetched_word   (seq_word),
    .held_disp      (seq_disp),
    .pk_byte        (pk_byte),
    .up_word        (up_word),
    .src_addr_q     (seq_src_addr),
    .dst_addr_q     (seq_dst_addr),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ack        (mem_ack),
    .mem_rdata      (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_src_addr <= '0;
      out_dst_addr <= '0;
    end else if (accept && !in_mem) begin
      out_valid    <= 1'b1;
      out_data     <= in_unpack ? up_word : {in_keep_hi, pk_byte};
      out_src_addr <= in_src_addr;
      out_dst_addr <= in_dst_addr;
    end else if (seq_done) begin
      out_valid    <= 1'b1;
      out_data     <= seq_unpack ? up_word : {{(WORD_W-BYTE_W){1'b0}}, pk_byte};
      out_src_addr <= seq_src_addr;
      out_dst_addr <= seq_dst_addr;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_mem) |=> out_valid); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_MEM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!in_ready && !out_valid)); // R7

  AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !out_valid); // R7
endmodule

// File: tb/sim_bcd_digit_converter.sv
`timescale 1ns/1ps
module sim_bcd_digit_converter;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_unpack = 1'b0, in_mem = 1'b0, out_ready = 1'b1;
  logic [15:0] in_src = '0, in_disp = '0;
  logic [7:0]  in_keep_hi = '0;
  logic [AW-1:0] in_src_addr = '0, in_dst_addr = '0;
  logic in_ready, out_valid, mem_req, mem_we;
  logic [15:0] out_data;
  logic [AW-1:0] out_src_addr, out_dst_addr, mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_ack = 1'b0;

  logic [7:0] bmem [64];
  logic       pl_en = 1'b0;
  logic [5:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic       log_clr = 1'b0;
  logic [AW-1:0] wlog [4];
  int unsigned wcount = 0;
  logic [AW-1:0] rlog [4];
  int unsigned rcount = 0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bcd_digit_converter #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_unpack(in_unpack), .in_mem(in_mem), .in_src(in_src), .in_disp(in_disp),
    .in_keep_hi(in_keep_hi), .in_src_addr(in_src_addr), .in_dst_addr(in_dst_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_src_addr(out_src_addr), .out_dst_addr(out_dst_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledges a pending request every second cycle
  assign mem_rdata = bmem[mem_addr[5:0]];
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (pl_en) bmem[pl_addr] <= pl_data;
    if (log_clr) begin
      wcount <= 0;
      rcount <= 0;
    end else if (mem_req && mem_ack) begin
      if (mem_we) begin
        bmem[mem_addr[5:0]] <= mem_wdata;
        if (wcount < 4) wlog[wcount] <= mem_addr;
        wcount <= wcount + 1;
      end else begin
        if (rcount < 4) rlog[rcount] <= mem_addr;
        rcount <= rcount + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  // register-form operation; checks the result one cycle after acceptance
  task automatic reg_op(input string req, input logic unp, input logic [15:0] src,
                        input logic [15:0] disp, input logic [7:0] keep,
                        input logic [15:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_mem = 1'b0; in_unpack = unp; in_src = src; in_disp = disp;
    in_keep_hi = keep; in_src_addr = 16'h1234; in_dst_addr = 16'h5678;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " data"}, {16'd0, out_data}, {16'd0, exp});
  endtask

  task automatic wait_result(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic t_reset;
    chk("R11 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R11 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R10 idle no request", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_pack_reg;
    reg_op("R1 pack 3736+0", 1'b0, 16'h3736, 16'h0000, 8'h00, 16'h0076);
    chk("R4 src addr passthrough", {16'd0, out_src_addr}, 32'h1234);
    chk("R4 dst addr passthrough", {16'd0, out_dst_addr}, 32'h5678);
    reg_op("R1 pack 3736+0102", 1'b0, 16'h3736, 16'h0102, 8'h00, 16'h0088);
    reg_op("R5 pack keeps upper byte", 1'b0, 16'h3736, 16'h0000, 8'hAB, 16'hAB76);
  endtask

  task automatic t_unpack_reg;
    reg_op("R2 unpack 76+3030", 1'b1, 16'h0076, 16'h3030, 8'h00, 16'h3736);
    reg_op("R2 unpack ignores src high byte", 1'b1, 16'hFF76, 16'h3030, 8'h55, 16'h3736);
  endtask

  task automatic t_wrap;
    reg_op("R3 pack wrap", 1'b0, 16'hFFFF, 16'h0002, 8'h00, 16'h0001);
    reg_op("R3 unpack wrap", 1'b1, 16'h0099, 16'hF800, 8'h00, 16'h0109);
  endtask

  task automatic t_backpressure;
    logic [15:0] first;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_mem = 1'b0; in_unpack = 1'b1; in_src = 16'h0042; in_disp = 16'h3030;
    @(negedge clk);
    in_valid = 1'b0;
    first = out_data;
    chk("R6 result present", {16'd0, first}, 32'h3432);
    repeat (3) @(negedge clk);
    chk("R6 valid held", {31'd0, out_valid}, 32'd1);
    chk("R6 data held", {16'd0, out_data}, {16'd0, first});
    chk("R6 in_ready low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R6 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_pack_mem;
    bit got;
    preload(6'h20, 8'h37);
    preload(6'h21, 8'h36);
    preload(6'h2F, 8'h00);
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    in_valid = 1'b1; in_mem = 1'b1; in_unpack = 1'b0; in_disp = 16'h0000;
    in_src_addr = 16'h0022; in_dst_addr = 16'h0030;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 busy blocks input", {31'd0, in_ready}, 32'd0);
    wait_result(got);
    chk("R8 result arrives", {31'd0, got}, 32'd1);
    chk("R8 data", {16'd0, out_data}, 32'h0076);
    chk("R8 final src", {16'd0, out_src_addr}, 32'h0020);
    chk("R8 final dst", {16'd0, out_dst_addr}, 32'h002F);
    chk("R8 first read low byte", {16'd0, rlog[0]}, 32'h0021);
    chk("R8 second read high byte", {16'd0, rlog[1]}, 32'h0020);
    chk("R8 one write", wcount, 32'd1);
    chk("R8 memory byte", {24'd0, bmem[6'h2F]}, 32'h76);
  endtask

  task automatic t_unpack_mem;
    bit got;
    preload(6'h27, 8'h76);
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    in_valid = 1'b1; in_mem = 1'b1; in_unpack = 1'b1; in_disp = 16'h3030;
    in_src_addr = 16'h0028; in_dst_addr = 16'h003C;
    @(negedge clk);
    in_valid = 1'b0;
    wait_result(got);
    chk("R9 result arrives", {31'd0, got}, 32'd1);
    chk("R9 data", {16'd0, out_data}, 32'h3736);
    chk("R9 final src", {16'd0, out_src_addr}, 32'h0027);
    chk("R9 final dst", {16'd0, out_dst_addr}, 32'h003A);
    chk("R9 one read", rcount, 32'd1);
    chk("R9 write count", wcount, 32'd2);
    chk("R9 low byte first", {16'd0, wlog[0]}, 32'h003B);
    chk("R9 high byte second", {16'd0, wlog[1]}, 32'h003A);
    chk("R9 mem low byte", {24'd0, bmem[6'h3B]}, 32'h36);
    chk("R9 mem high byte", {24'd0, bmem[6'h3A]}, 32'h37);
    @(negedge clk);
    chk("R10 idle after sequence", {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_pack_reg;
    t_unpack_reg;
    t_wrap;
    t_backpressure;
    t_pack_mem;
    t_unpack_mem;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule